// File: doc/BRIEF.md
# Dual-Channel Audio Sample FIFO with Threshold Interrupts

This block holds audio samples for a sound controller in two independent byte-wide channels. Each channel has one storage array. When the controller runs in streaming mode, host writes go to a write pointer and the playback engine pops bytes from a read pointer. Each channel keeps an occupancy count and two sticky status flags. The first flag reports that the channel is below half full. The second flag reports that the channel has just become full or just become empty. Crossing a threshold raises a pending interrupt in the channel, and the block's interrupt output is the OR of the two channels' pending requests.

In any mode other than streaming, the same arrays act as plain addressed memory. A host write stores a byte at the address given with it, and a host read returns the byte at a given address. The host clears both channels' flags and pending interrupts by reading one shared status byte. Writing a new mode value empties both channels.

Top module: `snd_sample_fifo`

## Requirements
- R1: After reset the mode is 0 (not streaming), both half-interrupt enables are 1, and all of the following are 0: both status pairs, `irq`, `pop_data_a`, `pop_data_b`, `rd_data` and `stat_data`.
- R2: When the mode equals 1, a write stores `wr_data` at the selected channel's write pointer. The write pointer then advances modulo DEPTH and the count increments. A pop that is accepted loads the byte at the read pointer onto that channel's pop data output on the next clock edge, in first-in first-out order, and then advances the read pointer modulo DEPTH.
- R3: A pop on a channel whose count is 0 is ignored, and the pop data output keeps its previous value.
- R4: A streaming write to a channel whose count is DEPTH-1 stores the byte at the write pointer. It does not advance the pointer, does not change the count and changes neither the status nor the interrupt.
- R5: When the mode is not 1, a write stores `wr_data` at `wr_addr` and leaves the pointers and the count alone. A host read returns the byte at `rd_addr` of channel `rd_sel` on `rd_data` one cycle later, and `rd_data` holds when no read is requested.
- R6: After every accepted push or pop, the half bit (status bit 0) is 1 when the count is below DEPTH/2 and 0 otherwise.
- R7: When the channel's half-interrupt enable is 1, a pending interrupt is raised in two cases: a push that brings the count to exactly DEPTH/2, and a pop that brings the count to exactly DEPTH/2-1. When the enable is 0, neither case raises an interrupt.
- R8: A push that brings the count to DEPTH-1, or a pop that brings it to 0, sets the full/empty bit (status bit 1) and raises a pending interrupt whatever the enable is.
- R9: A status read captures, on the next edge, the byte {4'b0, B.fe, B.half, A.fe, A.half} onto `stat_data`. The same edge clears both status pairs and both pending interrupts. An event in the same cycle as the read is kept.
- R10: `irq` is the OR of the two channels' pending interrupts. It stays high until a status read or a mode change.
- R11: A mode write whose value differs from the current mode clears both channels' pointers, counts, status and pending interrupts. This takes priority over a push or pop in the same cycle. Stored bytes are kept. A mode write with the same value has no effect.
- R12: The two channels are independent. Traffic on one channel never changes the other channel's count, data or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | New mode value (1 selects streaming) |
| ien_we | input | 1 | Half-interrupt enable write strobe |
| ien_sel | input | 1 | Channel whose enable is written (0 = A, 1 = B) |
| ien_val | input | 1 | New enable value |
| wr_en | input | 1 | Host data write strobe |
| wr_sel | input | 1 | Channel written (0 = A, 1 = B) |
| wr_addr | input | ADDR_W | Byte address used when not streaming |
| wr_data | input | DATA_W | Byte written |
| pop_en | input | 2 | Pop requests from playback, bit 0 = A, bit 1 = B |
| pop_data_a | output | DATA_W | Last byte popped from channel A |
| pop_data_b | output | DATA_W | Last byte popped from channel B |
| rd_en | input | 1 | Host addressed read strobe |
| rd_sel | input | 1 | Channel read (0 = A, 1 = B) |
| rd_addr | input | ADDR_W | Byte address read |
| rd_data | output | DATA_W | Result of the last host read |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_data | output | 8 | Status byte captured by the last status read |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W = 4, so each channel holds 16 bytes. With that size the push trigger sits at 8, the pop trigger at 7, the full level at 15, and pointer wrap all lie a few operations apart. A random mix of pushes, pops, status reads, enable changes and rare mode changes therefore crosses every threshold and wraps both pointers many times. Directed steps pin down overflow at the full level, a pop on an empty channel, the effect of a mode write with a changed value and with the same value, and status reads that coincide with threshold events.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;

  // Sticky per-channel flags; bit 0 = below half, bit 1 = full/empty event
  typedef struct packed {
    logic fe;
    logic half;
  } fifo_stat_t;

  localparam logic [7:0] MODE_STREAM = 8'd1;
  localparam int         NUM_CH      = 2;

endpackage

// File: rtl/snd_fifo_mode.sv
module snd_fifo_mode
  import snd_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  output logic       stream,
  output logic       flush
);

  logic [7:0] mode_q;
  logic [7:0] mode_d;
  logic       mode_en;

  always_comb begin
    flush   = mode_we && (mode_wdata != mode_q);
    mode_en = mode_we;
    mode_d  = mode_wdata;
    stream  = (mode_q == MODE_STREAM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/snd_fifo_ram.sv
module snd_fifo_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ra_en,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic              rb_en,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Registered read ports, each with its own enable; hold when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_data <= '0;
    end else if (ra_en) begin
      ra_data <= mem[ra_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_data <= '0;
    end else if (rb_en) begin
      rb_data <= mem[rb_addr];
    end
  end

endmodule

// File: rtl/snd_fifo_chan.sv
module snd_fifo_chan
  import snd_fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stream,
  input  logic              flush,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              ien_we,
  input  logic              ien_val,
  input  logic              stat_clr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] rd_data,
  output fifo_stat_t        stat,
  output logic              irq_pend,
  output logic              evt
);

  localparam logic [ADDR_W-1:0] LVL_FULL  = '1;
  localparam logic [ADDR_W-1:0] LVL_EMPTY = '0;
  localparam logic [ADDR_W-1:0] LVL_HALF  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] LVL_BELOW = {1'b0, {(ADDR_W-1){1'b1}}};

  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [ADDR_W-1:0] rptr_q, rptr_d;
  logic [ADDR_W-1:0] cnt_q,  cnt_d;
  fifo_stat_t        stat_q, stat_d;
  logic              irq_q,  irq_d;
  logic              ien_q;
  logic              push_ok, pop_ok;
  logic              ev_half, ev_fe;
  logic              ptr_en, flag_en;
  logic [ADDR_W-1:0] mem_waddr;

  // ---------------- next-state ----------------
  always_comb begin
    push_ok = push && stream && !flush && (cnt_q != LVL_FULL);
    pop_ok  = pop && !flush && (cnt_q != LVL_EMPTY);

    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = wptr_q + 1'b1;
    if (pop_ok)  rptr_d = rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end

    ev_fe   = (push_ok && !pop_ok && (cnt_d == LVL_FULL)) ||
              (pop_ok && !push_ok && (cnt_d == LVL_EMPTY));
    ev_half = ien_q &&
              ((push_ok && !pop_ok && (cnt_d == LVL_HALF)) ||
               (pop_ok && !push_ok && (cnt_d == LVL_BELOW)));

    stat_d = stat_q;
    irq_d  = irq_q;
    if (flush) begin
      stat_d = '0;
      irq_d  = 1'b0;
    end else begin
      if (stat_clr) begin
        stat_d = '0;
        irq_d  = 1'b0;
      end
      if (push_ok || pop_ok) stat_d.half = (cnt_d <= LVL_BELOW);
      if (ev_fe)             stat_d.fe   = 1'b1;
      if (ev_fe || ev_half)  irq_d       = 1'b1;
    end

    ptr_en  = flush || push_ok || pop_ok;
    flag_en = flush || stat_clr || push_ok || pop_ok;
    mem_waddr = stream ? wptr_q : push_addr;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else if (flag_en) begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b1;
    end else if (ien_we) begin
      ien_q <= ien_val;
    end
  end

  snd_fifo_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (push),
    .waddr   (mem_waddr),
    .wdata   (push_data),
    .ra_en   (pop_ok),
    .ra_addr (rptr_q),
    .ra_data (pop_data),
    .rb_en   (rd_en),
    .rb_addr (rd_addr),
    .rb_data (rd_data)
  );

  assign stat     = stat_q;
  assign irq_pend = irq_q;
  assign evt      = ev_fe || ev_half;

  // ---------------- assertions ----------------
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == LVL_EMPTY) |=> $stable(pop_data))
    else $error("empty pop changed pop data");

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && stream && !flush && !pop && cnt_q == LVL_FULL)
      |=> (cnt_q == LVL_FULL && $stable(wptr_q)))
    else $error("push at full level moved pointer or count");

  p_direct_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !stream && !flush && !pop) |=> ($stable(wptr_q) && $stable(cnt_q)))
    else $error("addressed write moved pointer");

  p_full_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && stream && !flush && !pop && cnt_q == LVL_FULL - 1'b1)
      |=> (stat_q.fe && irq_q))
    else $error("reaching full level did not flag");

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == LVL_EMPTY && wptr_q == '0 && rptr_q == '0 && !irq_q && stat_q == '0))
    else $error("mode change did not empty channel");

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LVL_FULL) |=> (cnt_q == LVL_FULL || cnt_q == LVL_FULL - 1'b1 || cnt_q == LVL_EMPTY))
    else $error("count left full level illegally");

endmodule

// File: rtl/snd_sample_fifo.sv
module snd_sample_fifo
  import snd_fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [7:0]        mode_wdata,
  input  logic              ien_we,
  input  logic              ien_sel,
  input  logic              ien_val,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        pop_en,
  output logic [DATA_W-1:0] pop_data_a,
  output logic [DATA_W-1:0] pop_data_b,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_rd,
  output logic [7:0]        stat_data,
  output logic              irq
);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              stream, flush;
  logic [DATA_W-1:0] ch_pop [NUM_CH];
  logic [DATA_W-1:0] ch_rd  [NUM_CH];
  fifo_stat_t        ch_stat [NUM_CH];
  logic [NUM_CH-1:0] ch_irq;
  logic [NUM_CH-1:0] ch_evt;
  logic              rd_sel_q;
  logic [7:0]        stat_vec;
  logic [7:0]        stat_q;

  // Reset: asserted asynchronously, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  snd_fifo_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .stream     (stream),
    .flush      (flush)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    snd_fifo_chan #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .stream    (stream),
      .flush     (flush),
      .push      (wr_en && (wr_sel == 1'(g))),
      .push_addr (wr_addr),
      .push_data (wr_data),
      .pop       (pop_en[g]),
      .ien_we    (ien_we && (ien_sel == 1'(g))),
      .ien_val   (ien_val),
      .stat_clr  (stat_rd),
      .rd_en     (rd_en && (rd_sel == 1'(g))),
      .rd_addr   (rd_addr),
      .pop_data  (ch_pop[g]),
      .rd_data   (ch_rd[g]),
      .stat      (ch_stat[g]),
      .irq_pend  (ch_irq[g]),
      .evt       (ch_evt[g])
    );
  end

  always_comb begin
    stat_vec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      stat_vec[2*i +: 2] = {ch_stat[i].fe, ch_stat[i].half};
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stat_q <= '0;
    end else if (stat_rd) begin
      stat_q <= stat_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_sel_q <= 1'b0;
    end else if (rd_en) begin
      rd_sel_q <= rd_sel;
    end
  end

  assign pop_data_a = ch_pop[0];
  assign pop_data_b = ch_pop[1];
  assign rd_data    = ch_rd[rd_sel_q];
  assign stat_data  = stat_q;
  assign irq        = |ch_irq;

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq && !stat_rd && !flush) |=> irq)
    else $error("interrupt dropped without status read");

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stat_rd && !flush && ch_evt == '0) |=> !irq)
    else $error("status read did not clear interrupt");

  p_stat_top_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_rd |=> (stat_data[7:4] == 4'b0))
    else $error("unused status bits set");

endmodule

// File: tb/sim_snd_sample_fifo.sv
module sim_snd_sample_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int B_AW       = 4;
  localparam int B_DEPTH    = 1 << B_AW;
  localparam int B_HALF     = B_DEPTH / 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mode_we;
  logic [7:0]      mode_wdata;
  logic            ien_we, ien_sel, ien_val;
  logic            wr_en, wr_sel;
  logic [B_AW-1:0] wr_addr;
  logic [7:0]      wr_data;
  logic [1:0]      pop_en;
  logic [7:0]      pop_data_a, pop_data_b;
  logic            rd_en, rd_sel;
  logic [B_AW-1:0] rd_addr;
  logic [7:0]      rd_data;
  logic            stat_rd;
  logic [7:0]      stat_data;
  logic            irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state
  logic [7:0] m_mem [2][B_DEPTH];
  int         m_wp [2];
  int         m_rp [2];
  int         m_cnt [2];
  logic [1:0] m_st [2];
  bit         m_pend [2];
  bit         m_ien [2];
  logic [7:0] m_mode;
  logic [7:0] e_pop [2];
  logic [7:0] e_rd;
  logic [7:0] e_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_sample_fifo #(.ADDR_W(B_AW), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ien_we(ien_we), .ien_sel(ien_sel), .ien_val(ien_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .pop_en(pop_en), .pop_data_a(pop_data_a), .pop_data_b(pop_data_b),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .stat_rd(stat_rd), .stat_data(stat_data), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic idle_inputs();
    mode_we = 0; mode_wdata = 0; ien_we = 0; ien_sel = 0; ien_val = 0;
    wr_en = 0; wr_sel = 0; wr_addr = 0; wr_data = 0; pop_en = 0;
    rd_en = 0; rd_sel = 0; rd_addr = 0; stat_rd = 0;
  endtask

  function automatic void model_reset();
    for (int f = 0; f < 2; f++) begin
      m_wp[f] = 0; m_rp[f] = 0; m_cnt[f] = 0; m_st[f] = 0;
      m_pend[f] = 0; m_ien[f] = 1; e_pop[f] = 0;
    end
    m_mode = 0; e_rd = 0; e_stat = 0;
  endfunction

  // Apply the current inputs to the model, clock once, compare outputs.
  task automatic tick(input string req);
    bit flush, stream, push, pok, qok;
    int nc;
    flush  = mode_we && (mode_wdata != m_mode);
    stream = (m_mode == 8'd1);
    if (stat_rd) e_stat = {4'b0, m_st[1], m_st[0]};
    if (rd_en)   e_rd   = m_mem[rd_sel][rd_addr];
    for (int f = 0; f < 2; f++) begin
      push = wr_en && (wr_sel == 1'(f));
      pok  = push && stream && !flush && (m_cnt[f] != B_DEPTH-1);
      qok  = pop_en[f] && !flush && (m_cnt[f] != 0);
      if (qok) e_pop[f] = m_mem[f][m_rp[f]];
      if (push) begin
        if (stream) m_mem[f][m_wp[f]] = wr_data;
        else        m_mem[f][wr_addr] = wr_data;
      end
      if (flush) begin
        m_wp[f] = 0; m_rp[f] = 0; m_cnt[f] = 0; m_st[f] = 0; m_pend[f] = 0;
      end else begin
        if (stat_rd) begin m_st[f] = 0; m_pend[f] = 0; end
        nc = m_cnt[f] + int'(pok) - int'(qok);
        if (pok) m_wp[f] = (m_wp[f] + 1) % B_DEPTH;
        if (qok) m_rp[f] = (m_rp[f] + 1) % B_DEPTH;
        if (pok || qok) m_st[f][0] = (nc < B_HALF);
        if ((pok && !qok && nc == B_DEPTH-1) || (qok && !pok && nc == 0)) begin
          m_st[f][1] = 1; m_pend[f] = 1;
        end
        if (m_ien[f] && ((pok && !qok && nc == B_HALF) || (qok && !pok && nc == B_HALF-1)))
          m_pend[f] = 1;
        m_cnt[f] = nc;
      end
      if (ien_we && (ien_sel == 1'(f))) m_ien[f] = ien_val;
    end
    if (mode_we) m_mode = mode_wdata;
    @(posedge clk);
    #1;
    chk(req, "irq (R10)", irq, m_pend[0] | m_pend[1]);
    chk(req, "pop_data_a (R2)", pop_data_a, e_pop[0]);
    chk(req, "pop_data_b (R12)", pop_data_b, e_pop[1]);
    chk(req, "rd_data (R5)", rd_data, e_rd);
    chk(req, "stat_data (R9)", stat_data, e_stat);
    idle_inputs();
  endtask

  task automatic push1(input bit sel, input logic [7:0] d, input string req);
    wr_en = 1; wr_sel = sel; wr_data = d; wr_addr = 0;
    tick(req);
  endtask

  task automatic pop1(input bit sel, input string req);
    pop_en = sel ? 2'b10 : 2'b01;
    tick(req);
  endtask

  task automatic stat1(input string req);
    stat_rd = 1;
    tick(req);
  endtask

  task automatic set_mode(input logic [7:0] m, input string req);
    mode_we = 1; mode_wdata = m;
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    chk("R1", "irq", irq, 0);
    chk("R1", "pop_data_a", pop_data_a, 0);
    chk("R1", "pop_data_b", pop_data_b, 0);
    chk("R1", "rd_data", rd_data, 0);
    stat1("R1");
    chk("R1", "stat after reset", stat_data, 8'h00);

    // R5: addressed writes fill both arrays in non-streaming mode
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < B_DEPTH; a++) begin
        wr_en = 1; wr_sel = 1'(f); wr_addr = B_AW'(a); wr_data = 8'(f*16 + a) ^ 8'h5A;
        tick("R5");
      end
    for (int a = 0; a < B_DEPTH; a += 5) begin
      rd_en = 1; rd_sel = 1'(a & 1); rd_addr = B_AW'(a);
      tick("R5");
    end

    // R11: enter streaming mode, R3: pop on empty
    set_mode(8'd1, "R11");
    pop1(0, "R3");
    chk("R3", "empty pop keeps data", pop_data_a, 8'h00);

    // R7/R6: push to half with default enable
    for (int i = 0; i < B_HALF; i++) push1(0, 8'h10 + 8'(i), "R2");
    chk("R7", "irq at push to half", irq, 1);
    stat1("R9");
    chk("R9", "stat after half push", stat_data, 8'h00);
    chk("R9", "irq cleared by read", irq, 0);
    pop1(0, "R2");
    chk("R2", "first pop value", pop_data_a, 8'h10);
    chk("R7", "irq at pop below half", irq, 1);
    stat1("R6");
    chk("R6", "half bit set below half", stat_data, 8'h01);

    // R8: fill to full
    for (int i = 0; i < B_HALF; i++) push1(0, 8'h20 + 8'(i), "R8");
    chk("R8", "irq at full", irq, 1);
    stat1("R8");
    chk("R8", "fe bit at full", stat_data, 8'h02);

    // R4: push at full level
    push1(0, 8'hEE, "R4");
    chk("R4", "no irq from overflow push", irq, 0);
    rd_en = 1; rd_sel = 0; rd_addr = '0;
    tick("R4");
    chk("R4", "overflow byte stored at write pointer", rd_data, 8'hEE);
    stat1("R4");
    chk("R4", "no status from overflow push", stat_data, 8'h00);

    // Drain completely
    for (int i = 0; i < B_DEPTH-1; i++) pop1(0, "R2");
    chk("R8", "irq at empty", irq, 1);
    stat1("R8");
    chk("R8", "half and fe at empty", stat_data, 8'h03);
    pop1(0, "R3");
    chk("R3", "pop on empty holds last byte", pop_data_a, 8'h27);

    // R12: channel B independent; R11: same-value mode write is harmless
    for (int i = 0; i < 3; i++) push1(1, 8'hB0 + 8'(i), "R12");
    stat1("R12");
    chk("R12", "only B flagged", stat_data, 8'h04);
    set_mode(8'd1, "R11");
    pop1(1, "R11");
    chk("R11", "same mode write kept B contents", pop_data_b, 8'hB0);

    // R11: changed mode empties; R5: addressed write in mode 2
    set_mode(8'd2, "R11");
    wr_en = 1; wr_sel = 0; wr_addr = B_AW'(3); wr_data = 8'h99;
    tick("R5");
    rd_en = 1; rd_sel = 0; rd_addr = B_AW'(3);
    tick("R5");
    chk("R5", "addressed write read back", rd_data, 8'h99);
    pop1(1, "R11");
    chk("R11", "flushed B refuses pop", pop_data_b, 8'hB0);

    // R7: enable off suppresses the half interrupt
    ien_we = 1; ien_sel = 0; ien_val = 0;
    tick("R7");
    set_mode(8'd1, "R11");
    for (int i = 0; i < B_HALF; i++) push1(0, 8'h40 + 8'(i), "R7");
    chk("R7", "no irq with enable off", irq, 0);
    stat1("R7");
    chk("R7", "half cleared, no fe", stat_data, 8'h00);
    ien_we = 1; ien_sel = 0; ien_val = 1;
    tick("R7");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 300) == 0) begin
        mode_we = 1; mode_wdata = 8'($urandom % 3);
      end else if (m_mode != 8'd1 && ($urandom % 20) == 0) begin
        mode_we = 1; mode_wdata = 8'd1;
      end
      if (($urandom % 2) == 0) begin
        wr_en = 1; wr_sel = 1'($urandom); wr_addr = B_AW'($urandom); wr_data = 8'($urandom);
      end
      if (($urandom % 2) == 0) pop_en = 2'($urandom);
      if (($urandom % 8) == 0) stat_rd = 1;
      if (($urandom % 40) == 0) begin
        ien_we = 1; ien_sel = 1'($urandom); ien_val = 1'($urandom);
      end
      if (($urandom % 4) == 0) begin
        rd_en = 1; rd_sel = 1'($urandom); rd_addr = B_AW'($urandom);
      end
      tick("R10");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule